// File: doc/BRIEF.md
# I2C Byte-Command Master Controller

This block is the control half of an I2C master. A processor programs it through five byte-wide registers. It first loads a 16-bit clock divider while the core is disabled, then enables the core. After that it issues one command byte at a time. A single command byte can ask for a START condition, one byte written or read, and a STOP condition. The controller runs the requested phases in a fixed order, records the outcome in a status register and raises an interrupt flag when the command is over.

The controller does not produce the SCL and SDA waveforms itself. It breaks every phase into bit-level operations (start, stop, write one bit, read one bit) and hands them one at a time to an external bit engine over a valid/ready channel. `eng_valid` rises when an operation is offered, and `eng_op` and `eng_wbit` stay frozen until the engine raises `eng_ready`. The engine may hold `eng_ready` low for as long as it likes, and nothing else is offered while an operation is outstanding. The engine ends each accepted operation with a one-cycle `eng_done` pulse. That pulse carries the bit it sampled (`eng_rbit`) and a flag that marks lost arbitration (`eng_lost`). The divider value is presented on `clk_div` so that the engine can time its waveforms.

Top module: `i2c_byte_master`

## Requirements
- R1: Register offsets: 0 = divider bits 7:0, 1 = divider bits 15:8, 2 = control, 3 = transmit byte on write and receive byte on read, 4 = command on write and status on read. Offsets 0 and 1 read back what was written. `clk_div` = {offset 1, offset 0}. In the control register, bit7 = core enable, bit6 = interrupt enable and bit5 = master select; the other bits read 0.
- R2: Writes to offsets 0 and 1 are ignored while control bit7 is 1.
- R3: A command is accepted only if three things hold: control bit7 is 1, no command is in progress, and at least one action bit is set. The action bits are bit7 START, bit6 STOP, bit5 READ and bit4 WRITE. Status bit1 (in progress) is 1 from the cycle after acceptance until the command ends. Command writes that are not accepted start no engine operation.
- R4: Engine op codes are 0 = START, 1 = STOP, 2 = write bit, 3 = read bit. The phases of one command run in the order START, then the data byte, then STOP, and phases not requested are skipped.
- R5: A write byte sends the transmit byte as eight write-bit operations, MSB first. One read-bit operation follows for the acknowledge slot. The bit sampled there is stored in status bit7, where 1 means NACK.
- R6: A read byte issues eight read-bit operations, MSB first. One write-bit operation follows, carrying command bit3: 1 sends NACK and 0 sends ACK. Once the command has ended, the assembled byte reads at offset 3.
- R7: Status bit0 (interrupt flag) sets whenever a command ends, including a STOP-only command. Any command write with bit0 = 1 clears it.
- R8: `irq` is high exactly when status bit0 and control bit6 are both 1.
- R9: If `eng_done` arrives with `eng_lost` = 1, the command is dropped with no further operations and no STOP. Status bit5 (arbitration lost) and bit0 are set and bit1 is cleared. Bit5 clears when the next command is accepted.
- R10: Status bit6 (bus busy) sets when a START operation completes and clears when a STOP operation completes.
- R11: While `eng_valid` is 1 and `eng_ready` is 0, `eng_valid`, `eng_op` and `eng_wbit` hold their values.
- R12: A command with both READ and WRITE set performs only the write byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| clk_div | output | 16 | Divider value for the bit engine |
| eng_valid | output | 1 | Bit operation offered |
| eng_ready | input | 1 | Engine takes the offered operation |
| eng_op | output | 2 | Operation code |
| eng_wbit | output | 1 | Bit level for a write-bit operation |
| eng_done | input | 1 | Accepted operation finished (one-cycle pulse) |
| eng_rbit | input | 1 | Bit sampled by a read-bit operation, valid with `eng_done` |
| eng_lost | input | 1 | Arbitration lost, valid with `eng_done` |

## Verification
The bench drives the engine side from a model that logs every operation, so it checks bit order, the level in the acknowledge slot and phase ordering as a recorded sequence. A controller that shifts LSB first would show the transmit byte reversed in this log. One that inverts the ACK control would return ACK on the last read byte. The bench writes a STOP command while a command is still running. A controller that queued or merged it would log an extra STOP and clear the busy bit. Arbitration is lost in the middle of a byte. A design that finished the phase or still issued STOP would log operations past the point of loss. A design that never cleared the lost flag would report it again after a later clean command.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_DIVL = 3'd0;
  localparam logic [REG_AW-1:0] RA_DIVH = 3'd1;
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd2;
  localparam logic [REG_AW-1:0] RA_DATA = 3'd3;
  localparam logic [REG_AW-1:0] RA_CMD  = 3'd4;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WBIT  = 2'd2,
    OP_RBIT  = 2'd3
  } eng_op_e;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_BYTE  = 2'd1,
    PH_STOP  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_e;

  typedef struct packed {
    logic sta;
    logic sto;
    logic rd;
    logic wr;
    logic ack;
  } cmd_t;

endpackage

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [2*DW-1:0]     div_val,
  output logic                core_en,
  output logic [DW-1:0]       tx_byte,
  output logic                cmd_wr,
  output cmd_t                cmd,
  input  logic                seq_done,
  input  logic                seq_tip,
  input  logic                seq_al,
  input  logic                seq_nack,
  input  logic                seq_busy,
  input  logic [DW-1:0]       seq_rx,
  output logic                irq
);

  logic [DW-1:0] div_lo_q, div_hi_q;
  logic          en_q, ien_q, mst_q;
  logic          flag_q;
  logic          iack;

  assign cmd_wr  = bus_wr && (bus_addr == RA_CMD);
  assign cmd     = '{sta: bus_wdata[7], sto: bus_wdata[6], rd: bus_wdata[5],
                     wr: bus_wdata[4], ack: bus_wdata[3]};
  assign iack    = cmd_wr && bus_wdata[0];
  assign div_val = {div_hi_q, div_lo_q};
  assign core_en = en_q;
  assign irq     = flag_q && ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
      en_q     <= 1'b0;
      ien_q    <= 1'b0;
      mst_q    <= 1'b0;
      tx_byte  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        RA_DIVL: if (!en_q) div_lo_q <= bus_wdata;
        RA_DIVH: if (!en_q) div_hi_q <= bus_wdata;
        RA_CTRL: begin
          en_q  <= bus_wdata[7];
          ien_q <= bus_wdata[6];
          mst_q <= bus_wdata[5];
        end
        RA_DATA: tx_byte <= bus_wdata;
        default: ;
      endcase
    end
  end

  // completion wins over a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (seq_done) flag_q <= 1'b1;
    else if (iack)     flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_DIVL: bus_rdata = div_lo_q;
      RA_DIVH: bus_rdata = div_hi_q;
      RA_CTRL: bus_rdata = {en_q, ien_q, mst_q, {(DW-3){1'b0}}};
      RA_DATA: bus_rdata = seq_rx;
      RA_CMD:  bus_rdata = {seq_nack, seq_busy, seq_al, {(DW-5){1'b0}}, seq_tip, flag_q};
      default: bus_rdata = '0;
    endcase
  end

  p_div_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(div_val));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> flag_q);

endmodule

// File: rtl/i2c_bm_seq.sv
module i2c_bm_seq
  import i2c_bm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  cmd_t          cmd,
  input  logic          core_en,
  input  logic [DW-1:0] tx_byte,
  output logic          eng_valid,
  input  logic          eng_ready,
  output logic [1:0]    eng_op,
  output logic          eng_wbit,
  input  logic          eng_done,
  input  logic          eng_rbit,
  input  logic          eng_lost,
  output logic          tip,
  output logic          done,
  output logic          al,
  output logic          nack,
  output logic          busy,
  output logic [DW-1:0] rx_byte
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  sq_state_e     st_q;
  phase_e        ph_q;
  cmd_t          pend_q;
  logic [CW-1:0] bcnt_q;
  logic [DW-1:0] txsh_q, rxsh_q;
  logic          ack_slot, accept, finish;
  eng_op_e       op;

  assign ack_slot  = (bcnt_q == LAST);
  assign accept    = cmd_wr && core_en && (st_q == SQ_IDLE) &&
                     (cmd.sta || cmd.sto || cmd.rd || cmd.wr);
  assign tip       = (st_q != SQ_IDLE);
  assign eng_valid = (st_q == SQ_ISSUE);
  assign finish    = (st_q == SQ_WAIT) && eng_done;

  always_comb begin
    op       = OP_STOP;
    eng_wbit = 1'b0;
    case (ph_q)
      PH_START: op = OP_START;
      PH_STOP:  op = OP_STOP;
      PH_BYTE: begin
        if (pend_q.wr) begin
          op       = ack_slot ? OP_RBIT : OP_WBIT;
          eng_wbit = ack_slot ? 1'b0 : txsh_q[DW-1];
        end else begin
          op       = ack_slot ? OP_WBIT : OP_RBIT;
          eng_wbit = ack_slot ? pend_q.ack : 1'b0;
        end
      end
      default: op = OP_STOP;
    endcase
    eng_op = op;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      ph_q    <= PH_START;
      pend_q  <= '0;
      bcnt_q  <= '0;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
      al      <= 1'b0;
      nack    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        SQ_IDLE: if (accept) begin
          pend_q <= cmd;
          txsh_q <= tx_byte;
          bcnt_q <= '0;
          al     <= 1'b0;
          st_q   <= SQ_ISSUE;
          if (cmd.sta)               ph_q <= PH_START;
          else if (cmd.rd || cmd.wr) ph_q <= PH_BYTE;
          else                       ph_q <= PH_STOP;
        end
        SQ_ISSUE: if (eng_ready) st_q <= SQ_WAIT;
        SQ_WAIT: if (finish) begin
          if (eng_lost) begin
            // abandon: no STOP, nothing left pending
            pend_q <= '0;
            al     <= 1'b1;
            done   <= 1'b1;
            st_q   <= SQ_IDLE;
          end else begin
            case (ph_q)
              PH_START: begin
                busy       <= 1'b1;
                pend_q.sta <= 1'b0;
                if (pend_q.rd || pend_q.wr) begin
                  ph_q <= PH_BYTE;
                  st_q <= SQ_ISSUE;
                end else if (pend_q.sto) begin
                  ph_q <= PH_STOP;
                  st_q <= SQ_ISSUE;
                end else begin
                  done <= 1'b1;
                  st_q <= SQ_IDLE;
                end
              end
              PH_BYTE: begin
                if (!ack_slot) begin
                  if (pend_q.wr) txsh_q <= {txsh_q[DW-2:0], 1'b0};
                  else           rxsh_q <= {rxsh_q[DW-2:0], eng_rbit};
                  bcnt_q <= bcnt_q + 1'b1;
                  st_q   <= SQ_ISSUE;
                end else begin
                  if (pend_q.wr) nack    <= eng_rbit;
                  else           rx_byte <= rxsh_q;
                  pend_q.rd <= 1'b0;
                  pend_q.wr <= 1'b0;
                  bcnt_q    <= '0;
                  if (pend_q.sto) begin
                    ph_q <= PH_STOP;
                    st_q <= SQ_ISSUE;
                  end else begin
                    done <= 1'b1;
                    st_q <= SQ_IDLE;
                  end
                end
              end
              default: begin
                busy       <= 1'b0;
                pend_q.sto <= 1'b0;
                done       <= 1'b1;
                st_q       <= SQ_IDLE;
              end
            endcase
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  p_hold_offer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_op) && $stable(eng_wbit)));

  p_lost_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && eng_lost) |=> (!tip && al && done));

  p_stop_frees_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !eng_lost && ph_q == PH_STOP) |=> !busy);

  p_start_takes_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !eng_lost && ph_q == PH_START) |=> busy);

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic [2*DW-1:0]   clk_div,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [1:0]        eng_op,
  output logic              eng_wbit,
  input  logic              eng_done,
  input  logic              eng_rbit,
  input  logic              eng_lost
);

  logic          core_en, cmd_wr;
  cmd_t          cmd;
  logic [DW-1:0] tx_byte, rx_byte;
  logic          tip, done, al, nack, busy;

  i2c_bm_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .div_val   (clk_div),
    .core_en   (core_en),
    .tx_byte   (tx_byte),
    .cmd_wr    (cmd_wr),
    .cmd       (cmd),
    .seq_done  (done),
    .seq_tip   (tip),
    .seq_al    (al),
    .seq_nack  (nack),
    .seq_busy  (busy),
    .seq_rx    (rx_byte),
    .irq       (irq)
  );

  i2c_bm_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd       (cmd),
    .core_en   (core_en),
    .tx_byte   (tx_byte),
    .eng_valid (eng_valid),
    .eng_ready (eng_ready),
    .eng_op    (eng_op),
    .eng_wbit  (eng_wbit),
    .eng_done  (eng_done),
    .eng_rbit  (eng_rbit),
    .eng_lost  (eng_lost),
    .tip       (tip),
    .done      (done),
    .al        (al),
    .nack      (nack),
    .busy      (busy),
    .rx_byte   (rx_byte)
  );

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (u_regs.flag_q && u_regs.ien_q));

endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;
  logic [15:0] clk_div;
  logic        eng_valid, eng_wbit;
  logic [1:0]  eng_op;
  logic        eng_ready = 1'b0, eng_done = 1'b0, eng_rbit = 1'b0, eng_lost = 1'b0;

  int vectors = 0;
  int fails = 0;

  // engine model state
  logic [1:0]  lop  [0:63];
  logic        lbit [0:63];
  int          n = 0;
  int          lose_idx = -1;
  int          hold_err = 0;
  logic [15:0] resp_pat = '0;

  // expected operation list
  logic [1:0]  eop  [0:63];
  logic        ebit [0:63];
  int          ecnt = 0;

  always #10 clk = ~clk;

  i2c_byte_master dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .clk_div(clk_div),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_op(eng_op), .eng_wbit(eng_wbit),
    .eng_done(eng_done), .eng_rbit(eng_rbit), .eng_lost(eng_lost)
  );

  // bit engine model: holds ready low one cycle, logs, answers later
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && eng_valid) begin
        logic [1:0] so;
        logic       sb;
        so = eng_op;
        sb = eng_wbit;
        @(negedge clk);
        if (!eng_valid || eng_op !== so || eng_wbit !== sb) hold_err++;
        eng_ready = 1'b1;
        if (n < 64) begin
          lop[n]  = so;
          lbit[n] = sb;
        end
        @(negedge clk);
        eng_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        eng_done = 1'b1;
        eng_lost = (n == lose_idx);
        eng_rbit = (so == 2'd3) ? resp_pat[15] : 1'b0;
        if (so == 2'd3) resp_pat = resp_pat << 1;
        n++;
        @(negedge clk);
        eng_done = 1'b0;
        eng_lost = 1'b0;
        eng_rbit = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    rd(3'd4, s);
    while (s[1]) rd(3'd4, s);
  endtask

  task automatic exp_clear();
    ecnt = 0;
  endtask

  task automatic exp_push(input logic [1:0] o, input logic b);
    eop[ecnt]  = o;
    ebit[ecnt] = b;
    ecnt++;
  endtask

  task automatic exp_wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) exp_push(2'd2, v[i]);
    exp_push(2'd3, 1'b0);
  endtask

  task automatic exp_rbyte(input logic nk);
    for (int i = 0; i < 8; i++) exp_push(2'd3, 1'b0);
    exp_push(2'd2, nk);
  endtask

  task automatic cmp_ops(input string req, input int base);
    int mis;
    mis = 0;
    chk(req, n - base, ecnt);
    for (int i = 0; i < ecnt; i++) begin
      if (base + i < 64) begin
        if (lop[base+i] !== eop[i]) mis++;
        else if (eop[i] == 2'd2 && lbit[base+i] !== ebit[i]) mis++;
      end
    end
    chk(req, mis, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd4, v); chk("R1 reset status", v, 8'h00);
    rd(3'd2, v); chk("R1 reset control", v, 8'h00);
    chk("R8 reset irq", irq, 1'b0);
    chk("R4 reset no offer", eng_valid, 1'b0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, v); chk("R1 divider low", v, 8'h34);
    rd(3'd1, v); chk("R1 divider high", v, 8'h12);
    chk("R1 clk_div", clk_div, 16'h1234);
    wr(3'd2, 8'hFF);
    rd(3'd2, v); chk("R1 control bits", v, 8'hE0);
    wr(3'd0, 8'h55);
    wr(3'd1, 8'h66);
    rd(3'd0, v); chk("R2 low locked", v, 8'h34);
    chk("R2 clk_div locked", clk_div, 16'h1234);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    int b;
    b = n;
    wr(3'd2, 8'h40);
    wr(3'd4, 8'h90);
    repeat (20) @(negedge clk);
    rd(3'd4, v); chk("R3 disabled no tip", v[1], 1'b0);
    chk("R3 disabled no ops", n - b, 0);
    wr(3'd2, 8'hE0);
  endtask

  task automatic t_start_write();
    logic [7:0] v;
    int b;
    b = n;
    resp_pat = 16'h0000;
    wr(3'd3, 8'hA5);
    wr(3'd4, 8'h90);
    rd(3'd4, v); chk("R3 tip after accept", v[1], 1'b1);
    wr(3'd4, 8'h40);
    wait_idle();
    repeat (8) @(negedge clk);
    exp_clear();
    exp_push(2'd0, 1'b0);
    exp_wbyte(8'hA5);
    cmp_ops("R4 R5 start+write ops", b);
    rd(3'd4, v); chk("R5 R7 R10 status", v, 8'h41);
    chk("R8 irq raised", irq, 1'b1);
  endtask

  task automatic t_iack();
    logic [7:0] v;
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R7 flag cleared", v[0], 1'b0);
    chk("R8 irq dropped", irq, 1'b0);
  endtask

  task automatic t_stop_masked();
    logic [7:0] v;
    int b;
    b = n;
    wr(3'd2, 8'hA0);
    wr(3'd4, 8'h40);
    wait_idle();
    exp_clear();
    exp_push(2'd1, 1'b0);
    cmp_ops("R4 stop-only ops", b);
    rd(3'd4, v); chk("R7 R10 stop status", v, 8'h01);
    chk("R8 irq masked", irq, 1'b0);
    wr(3'd2, 8'hE0);
    chk("R8 irq unmasked", irq, 1'b1);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_read(input logic [7:0] cmdv, input logic [7:0] data, input logic nk,
                        input logic with_stop, input string req);
    logic [7:0] v;
    int b;
    b = n;
    resp_pat = {data, 8'h00};
    wr(3'd4, cmdv);
    wait_idle();
    exp_clear();
    exp_rbyte(nk);
    if (with_stop) exp_push(2'd1, 1'b0);
    cmp_ops(req, b);
    rd(3'd3, v); chk(req, v, data);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_write_nack();
    logic [7:0] v;
    int b;
    b = n;
    resp_pat = 16'h8000;
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h10);
    wait_idle();
    exp_clear();
    exp_wbyte(8'h00);
    cmp_ops("R5 write ops", b);
    rd(3'd4, v); chk("R5 nack status", v, 8'h81);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_rd_wr_both();
    logic [7:0] v;
    int b;
    b = n;
    resp_pat = 16'h0000;
    wr(3'd3, 8'h0F);
    wr(3'd4, 8'h30);
    wait_idle();
    exp_clear();
    exp_wbyte(8'h0F);
    cmp_ops("R12 write wins", b);
    rd(3'd3, v); chk("R12 rx untouched", v, 8'hC3);
    rd(3'd4, v); chk("R12 ack status", v[7], 1'b0);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_arb_lost();
    logic [7:0] v;
    int b;
    b = n;
    resp_pat = 16'h0000;
    lose_idx = b + 3;
    wr(3'd3, 8'hF0);
    wr(3'd4, 8'hD0);
    wait_idle();
    repeat (10) @(negedge clk);
    lose_idx = -1;
    exp_clear();
    exp_push(2'd0, 1'b0);
    exp_push(2'd2, 1'b1);
    exp_push(2'd2, 1'b1);
    exp_push(2'd2, 1'b1);
    cmp_ops("R9 abandon ops", b);
    rd(3'd4, v); chk("R9 lost status", v, 8'h61);
    wr(3'd4, 8'h01);
    wr(3'd4, 8'h40);
    wait_idle();
    rd(3'd4, v); chk("R9 R10 lost flag cleared", v, 8'h01);
    wr(3'd4, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_disabled();
    t_start_write();
    t_iack();
    t_stop_masked();
    t_read(8'h68, 8'h3C, 1'b1, 1'b1, "R6 read nack+stop");
    t_read(8'h20, 8'hC3, 1'b0, 1'b0, "R6 read ack");
    t_write_nack();
    t_rd_wr_both();
    t_arb_lost();
    chk("R11 offer held", hold_err, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule